// File: doc/BRIEF.md
# CPU Maskable Interrupt Acceptance Core

This block sits on the processor side of an interrupt system. It watches sixteen request lines and records a new request on any line in a per-line flag. Fourteen lines are maskable. Each of those must be enabled by its own bit in an enable register, and it is also held back by a global mask bit and a debug mask bit. Two lines (line 0, the reset request, and line 15, the non-maskable request) skip every mask. The block offers one winning line to the processor. When the processor takes it, the block clears that line's flag and sets the global mask in the same clock. Interrupts therefore do not nest until software clears the global mask again.

The winning line goes out on a valid/ready stream. `take_valid` is high while any line qualifies, and `take_idx` carries the winning line number. The processor raises `take_ready` at a point where it can accept an interrupt, and the interrupt is taken on a clock where both are high. The back-pressure rules are these. While `take_ready` is low, no flag is consumed and no mask changes. The offer is re-evaluated every cycle, so a higher-priority arrival may replace the offered index, and the offer drops if its line loses qualification. Software reads and writes the enable and flag registers through plain ports. It sets and clears the two mask bits with strobes.

Top module: `irq_accept_core`

## Requirements
- R1: After reset, all flags and enable bits are 0, the global mask and debug mask are both 1, and `take_valid` is 0.
- R2: A 0-to-1 transition on `irq_req[i]` sets flag bit i at the next clock. A line held high sets its flag only once, so after the flag is cleared it stays clear until the line falls and rises again.
- R3: A maskable line (1 to 14) qualifies only when its flag is set, its enable bit is 1, the global mask is 0 and the debug mask is 0.
- R4: Lines 0 and 15 qualify whenever their flag is set, whatever the enable bits, global mask and debug mask hold.
- R5: A qualifying non-maskable line is always offered ahead of any maskable line, with line 0 ahead of line 15. Among maskable lines the lowest number is offered.
- R6: A clock with `take_valid` and `take_ready` both high takes line `take_idx`. At that edge the line's flag clears and the global mask becomes 1.
- R7: If a new 0-to-1 request on a line arrives in the same cycle that the line is taken, the flag stays set.
- R8: A write to the flag register replaces all flag bits with the written value, except that a 0-to-1 request in the same cycle still sets its bit.
- R9: `gmask_set` sets the global mask and `gmask_clr` clears it. If a strobe to set (software or a take) and `gmask_clr` arrive together, the mask ends up set.
- R10: `dbg_set` sets the debug mask and `dbg_clr` clears it. If both arrive together, the set wins.
- R11: While `take_ready` is low, flags and masks stay unchanged and a qualifying line stays offered.
- R12: A write to the enable register stores all 16 bits, and they read back unchanged on `en_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Request lines; a rising level is a new request |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 16 | Enable register write value |
| en_rdata | output | 16 | Enable register contents |
| flag_we | input | 1 | Flag register write strobe |
| flag_wdata | input | 16 | Flag register write value |
| flag_rdata | output | 16 | Flag register contents |
| gmask_set | input | 1 | Set the global mask |
| gmask_clr | input | 1 | Clear the global mask |
| gmask_o | output | 1 | Global mask state |
| dbg_set | input | 1 | Set the debug mask |
| dbg_clr | input | 1 | Clear the debug mask |
| dbg_o | output | 1 | Debug mask state |
| take_valid | output | 1 | A qualifying line is offered |
| take_ready | input | 1 | Processor can take an interrupt this cycle |
| take_idx | output | 4 | Number of the offered line |

## Verification
The two things that can land in the same cycle are a take, which clears a flag and sets the global mask, and a fresh request edge, a software flag write or a software mask clear aimed at the same state. The bench sets up these collisions on purpose. It raises a request on the very line being taken. It writes the flag register in the same cycle as a rising edge. It pulses `gmask_clr` together with a take. It judges each collision by reading `flag_rdata` and `gmask_o` one cycle later against the precedence stated in R7, R8 and R9.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
  localparam int unsigned LINES_DEF = 16;
  // lines that bypass every mask: 0 (reset request) and 15 (non-maskable)
  localparam logic [LINES_DEF-1:0] NM_DEF = 16'h8001;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          wr_en,
  input  logic [N-1:0]  wr_data,
  input  logic          take,
  input  logic [IW-1:0] take_idx,
  output logic [N-1:0]  flags
);
  logic [N-1:0] req_q, rise, clr_vec, base;

  assign rise    = req & ~req_q;
  assign clr_vec = take ? ({{(N-1){1'b0}}, 1'b1} << take_idx) : '0;
  // software write replaces, take clears, a new edge always sets
  assign base    = wr_en ? wr_data : (flags & ~clr_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      flags <= '0;
    end else begin
      req_q <= req;
      flags <= base | rise;
    end
  end

  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((flags & $past(rise)) == $past(rise)));

  p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en && !rise[take_idx]) |=> !flags[$past(take_idx)]);

  p_take_vs_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rise[take_idx]) |=> flags[$past(take_idx)]);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  input  logic         gm_set,
  input  logic         gm_clr,
  input  logic         take,
  input  logic         dbg_set,
  input  logic         dbg_clr,
  output logic [N-1:0] en_q,
  output logic         gmask,
  output logic         dbgm
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      gmask <= 1'b1;
      dbgm  <= 1'b1;
    end else begin
      if (en_we) en_q <= en_wdata;
      if (take || gm_set)  gmask <= 1'b1;
      else if (gm_clr)     gmask <= 1'b0;
      if (dbg_set)         dbgm  <= 1'b1;
      else if (dbg_clr)    dbgm  <= 1'b0;
    end
  end

  p_take_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> gmask);

  p_clr_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gm_clr && !gm_set && !take) |=> !gmask);

  p_dbg_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_set |=> dbgm);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N = 16,
  parameter logic [N-1:0] NM = irq_core_pkg::NM_DEF,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  flags,
  input  logic [N-1:0]  en,
  input  logic          gmask,
  input  logic          dbgm,
  output logic          valid,
  output logic [IW-1:0] idx
);
  logic [N-1:0]  nm_pend, mk_pend;
  logic [IW-1:0] nm_idx, mk_idx;

  assign nm_pend = flags & NM;
  assign mk_pend = flags & ~NM & en & {N{~gmask & ~dbgm}};

  // descending scan leaves the lowest set bit in each tier
  always_comb begin
    nm_idx = '0;
    mk_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (nm_pend[i]) nm_idx = IW'(i);
      if (mk_pend[i]) mk_idx = IW'(i);
    end
  end

  assign valid = (|nm_pend) || (|mk_pend);
  assign idx   = (|nm_pend) ? nm_idx : mk_idx;

  p_offer_has_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> flags[idx]);

  p_maskable_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !NM[idx]) |-> (en[idx] && !gmask && !dbgm));

  p_nm_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nm_pend != '0) |-> (valid && NM[idx]));
endmodule

// File: rtl/irq_accept_core.sv
module irq_accept_core #(
  parameter int unsigned N = irq_core_pkg::LINES_DEF,
  parameter logic [N-1:0] NM = irq_core_pkg::NM_DEF,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_req,
  input  logic          en_we,
  input  logic [N-1:0]  en_wdata,
  output logic [N-1:0]  en_rdata,
  input  logic          flag_we,
  input  logic [N-1:0]  flag_wdata,
  output logic [N-1:0]  flag_rdata,
  input  logic          gmask_set,
  input  logic          gmask_clr,
  output logic          gmask_o,
  input  logic          dbg_set,
  input  logic          dbg_clr,
  output logic          dbg_o,
  output logic          take_valid,
  input  logic          take_ready,
  output logic [IW-1:0] take_idx
);
  logic [N-1:0] flags, en_q;
  logic         gmask, dbgm, take;

  assign take = take_valid && take_ready;

  irq_flag_bank #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n), .req(irq_req),
    .wr_en(flag_we), .wr_data(flag_wdata),
    .take(take), .take_idx(take_idx), .flags(flags)
  );

  irq_mask_ctrl #(.N(N)) u_masks (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
    .gm_set(gmask_set), .gm_clr(gmask_clr), .take(take),
    .dbg_set(dbg_set), .dbg_clr(dbg_clr),
    .en_q(en_q), .gmask(gmask), .dbgm(dbgm)
  );

  irq_pick #(.N(N), .NM(NM)) u_pick (
    .clk(clk), .rst_n(rst_n), .flags(flags), .en(en_q),
    .gmask(gmask), .dbgm(dbgm), .valid(take_valid), .idx(take_idx)
  );

  assign en_rdata   = en_q;
  assign flag_rdata = flags;
  assign gmask_o    = gmask;
  assign dbg_o      = dbgm;

  p_stall_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_ready && !flag_we && !gmask_set && !gmask_clr
     && !dbg_set && !dbg_clr && !en_we) |=> (take_valid && $stable(flag_rdata)));
endmodule

// File: tb/tb_irq_accept_core.sv
module tb_irq_accept_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_req, en_wdata, en_rdata, flag_wdata, flag_rdata;
  logic        en_we, flag_we, gmask_set, gmask_clr, gmask_o;
  logic        dbg_set, dbg_clr, dbg_o, take_valid, take_ready;
  logic [3:0]  take_idx;
  int          total = 0, bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  irq_accept_core dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .en_we(en_we), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .flag_rdata(flag_rdata),
    .gmask_set(gmask_set), .gmask_clr(gmask_clr), .gmask_o(gmask_o),
    .dbg_set(dbg_set), .dbg_clr(dbg_clr), .dbg_o(dbg_o),
    .take_valid(take_valid), .take_ready(take_ready), .take_idx(take_idx)
  );

  typedef struct packed {
    logic [15:0] en;
    logic [15:0] fl;
    logic        gm_clr;
    logic        db_clr;
    logic        exp_v;
    logic [3:0]  exp_idx;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{16'h0004, 16'h0004, 1'b1, 1'b1, 1'b1, 4'd2},   // R3 all gates open
    '{16'h0000, 16'h0004, 1'b1, 1'b1, 1'b0, 4'd0},   // R3 enable off
    '{16'h0004, 16'h0004, 1'b0, 1'b1, 1'b0, 4'd0},   // R3 global mask on
    '{16'h0004, 16'h0004, 1'b1, 1'b0, 1'b0, 4'd0},   // R3 debug mask on
    '{16'hFFFF, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd0},   // R3 nothing pending
    '{16'h0000, 16'h8000, 1'b0, 1'b0, 1'b1, 4'd15},  // R4 line 15 bypass
    '{16'hFFFF, 16'h6020, 1'b1, 1'b1, 1'b1, 4'd5},   // R5 lowest maskable
    '{16'h4000, 16'h6020, 1'b1, 1'b1, 1'b1, 4'd14},  // R5 only enabled one
    '{16'hFFFF, 16'h8003, 1'b0, 1'b0, 1'b1, 4'd0},   // R5 line 0 first
    '{16'hFFFF, 16'h8006, 1'b1, 1'b1, 1'b1, 4'd15}   // R5 NM beats line 1
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    en_we = 0; flag_we = 0; gmask_set = 0; gmask_clr = 0;
    dbg_set = 0; dbg_clr = 0; take_ready = 0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_req = '0; en_wdata = '0; flag_wdata = '0; idle();
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 flags", flag_rdata, 0);
    chk("R1 enable", en_rdata, 0);
    chk("R1 gmask", gmask_o, 1);
    chk("R1 dbgm", dbg_o, 1);
    chk("R1 valid", take_valid, 0);

    // table walk: R3, R4, R5
    foreach (VEC[k]) begin
      gmask_set = 1; dbg_set = 1;
      en_we = 1; en_wdata = VEC[k].en;
      flag_we = 1; flag_wdata = VEC[k].fl;
      step();
      idle();
      gmask_clr = VEC[k].gm_clr; dbg_clr = VEC[k].db_clr;
      step();
      idle();
      chk("R3/R4/R5 valid", take_valid, VEC[k].exp_v);
      if (VEC[k].exp_v) chk("R3/R4/R5 idx", take_idx, VEC[k].exp_idx);
    end

    // R12 enable readback
    en_we = 1; en_wdata = 16'hA5C3; flag_we = 1; flag_wdata = 0;
    step(); idle();
    chk("R12 readback", en_rdata, 16'hA5C3);

    // R2 edge capture, held level sets once
    irq_req[3] = 1; step();
    chk("R2 edge sets", flag_rdata, 16'h0008);
    flag_we = 1; flag_wdata = 0; step(); idle();
    step();
    chk("R2 held level no reset", flag_rdata, 16'h0000);
    irq_req[3] = 0; step();
    irq_req[3] = 1; step();
    chk("R2 second edge", flag_rdata, 16'h0008);

    // R11 stall, then R6 take
    en_we = 1; en_wdata = 16'h0018; gmask_clr = 1; dbg_clr = 1;
    step(); idle();
    repeat (3) step();
    chk("R11 stall valid", take_valid, 1);
    chk("R11 stall idx", take_idx, 3);
    chk("R11 stall flags", flag_rdata, 16'h0008);
    chk("R11 stall gmask", gmask_o, 0);
    take_ready = 1; step(); idle();
    chk("R6 flag cleared", flag_rdata, 16'h0000);
    chk("R6 gmask set", gmask_o, 1);
    chk("R6 offer gone", take_valid, 0);

    // R7 take and new edge on the same line
    irq_req[4] = 1; step(); irq_req[4] = 0;
    gmask_clr = 1; step(); idle();
    chk("R7 offered", take_idx, 4);
    take_ready = 1; irq_req[4] = 1; step(); idle();
    chk("R7 flag kept", flag_rdata, 16'h0010);
    chk("R7 gmask", gmask_o, 1);

    // R8 write with simultaneous edge
    flag_we = 1; flag_wdata = 16'h0000; irq_req[6] = 1; step(); idle();
    chk("R8 write and edge", flag_rdata, 16'h0040);

    // R9 set and clear together
    gmask_set = 1; gmask_clr = 1; step(); idle();
    chk("R9 set beats clr", gmask_o, 1);
    gmask_clr = 1; step(); idle();
    chk("R9 clr", gmask_o, 0);
    en_we = 1; en_wdata = 16'h0040; step(); idle();
    chk("R9 offer line 6", take_idx, 6);
    take_ready = 1; gmask_clr = 1; step(); idle();
    chk("R9 take beats clr", gmask_o, 1);

    // R10 debug mask
    dbg_set = 1; dbg_clr = 1; step(); idle();
    chk("R10 set wins", dbg_o, 1);
    dbg_clr = 1; step(); idle();
    chk("R10 clr", dbg_o, 0);
    dbg_set = 1; step(); idle();
    chk("R10 set", dbg_o, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule